// File: doc/BRIEF.md
# Block Transfer Handshake Engine

This block moves a block of data between nodes of a packet network with a fixed request, grant and stream exchange. It holds two independent engines that share a node number. The initiating engine opens a transfer with a connection-request packet. That packet names the destination node, the destination resource (DRAM, the reconfiguration port or user logic), a word address and the number of data packets that will follow. The engine then waits for a connection-permission packet from that destination, and only after it arrives does it stream the announced number of DMA-data packets.

The answering engine is the matching receiver. It accepts a request addressed to its node and answers with a permission. For each data packet it accepts, it issues one burst-write command with the right address. It closes the transfer purely by counting packets, because the announced count makes a closing exchange unnecessary.

Data packets are handled at the header level here: each one stands for a 32-word burst, and the receiver turns it into one burst-write command. Routing and the memories behind the write commands sit outside this block.

Top module: `xfer_engine`

## Requirements
- R1: The header type field is bits [22:20], with 0 = connection request, 1 = connection permission, 2 = DMA control, 3 = DMA data and 4 = register control. The receiver ignores codes 5 to 7, which cause neither a grant nor a write on the following cycle.
- R2: After `tx_start` is sampled in idle, the next cycle shows `tx_pkt_valid` with a request header. The header carries type 0, the resource in bits [17:16], the own node in [7:4] and the destination in [3:0]. The argument word is {count[31:24], word address[23:0]}.
- R3: The initiator emits no data packet until a permission (type 1) arrives whose source field [7:4] equals the requested destination and whose destination field [3:0] equals the own node. A permission from any other source is ignored and leaves the engine waiting.
- R4: The cycle after a matching permission is sampled, the initiator starts emitting count data packets (type 3) on consecutive cycles. Their argument is the packet index 0 to count-1, and `tx_done` is high with the last one.
- R5: If no matching permission arrives within TIMEOUT cycles after the request, `tx_err` pulses for one cycle and the initiator returns to idle.
- R6: A request addressed to the own node gets a permission one cycle later, with source = own node and destination = the requester. Requests for other nodes are ignored.
- R7: The n-th accepted data packet (n from 0) from the granted source gives a write command one cycle later at address base + 32·n, for the resource named in the request.
- R8: The receiver counts the accepted packets and returns to idle with an `rx_done` pulse together with the last write. No packet follows the last data packet, and data from other sources or outside a transfer produces no write.
- R9: A request that arrives while a transfer is in progress is held, not refused. Its permission comes out one cycle after the cycle that shows `rx_done` for the current transfer.
- R10: A count of zero completes at once on both sides. The receiver shows its permission and `rx_done` together, and the initiator shows `tx_done` one cycle after the permission, with no data packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_node | input | 4 | Own node number |
| tx_start | input | 1 | Open a transfer (sampled in idle) |
| tx_dst | input | 4 | Destination node |
| tx_tgt | input | 2 | Destination resource: 0 DRAM, 1 reconfiguration port, 2 user logic |
| tx_addr | input | 24 | Destination word address |
| tx_count | input | 8 | Number of data packets |
| tx_grant_valid | input | 1 | Incoming permission packet valid |
| tx_grant_hdr | input | 23 | Incoming permission header |
| tx_pkt_valid | output | 1 | Outgoing initiator packet valid |
| tx_pkt_hdr | output | 23 | Outgoing initiator header |
| tx_pkt_arg | output | 32 | Outgoing initiator argument word |
| tx_busy | output | 1 | Initiator transfer open |
| tx_done | output | 1 | Initiator completed |
| tx_err | output | 1 | Initiator timed out |
| rx_pkt_valid | input | 1 | Incoming receiver packet valid |
| rx_pkt_hdr | input | 23 | Incoming receiver header |
| rx_pkt_arg | input | 32 | Incoming receiver argument word |
| rx_grant_valid | output | 1 | Outgoing permission valid |
| rx_grant_hdr | output | 23 | Outgoing permission header |
| wr_valid | output | 1 | Burst write command valid |
| wr_tgt | output | 2 | Burst write resource |
| wr_addr | output | 24 | Burst write start word address |
| rx_busy | output | 1 | Receiver transfer open |
| rx_done | output | 1 | Receiver completed |

## Verification
Every output is a register, so every reaction is due exactly one cycle after the input that causes it is sampled. This covers the request after a start, a grant after a request, a write after a data packet, and the done flags with the last item. The first data packet follows a permission by two cycles, the timeout flag follows the request by TIMEOUT cycles, and a deferred grant follows the receiver's done by one cycle. The bench drives and samples on the falling edge and checks each result on exactly the falling edge where it is due. On the cycles before that it checks that nothing has come out early.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int HDR_W   = 23;
  localparam int NODE_W  = 4;
  localparam int TGT_W   = 2;
  localparam int ADDR_W  = 24;
  localparam int CNT_W   = 8;
  localparam int ARG_W   = CNT_W + ADDR_W;
  localparam int BURST_SH = 5;  // 32 words per data packet

  typedef enum logic [2:0] {
    PK_REQ    = 3'd0,
    PK_PERM   = 3'd1,
    PK_DMACTL = 3'd2,
    PK_DATA   = 3'd3,
    PK_REGCTL = 3'd4
  } pk_type_e;

  function automatic logic [HDR_W-1:0] mk_hdr(input logic [2:0] t, input logic [TGT_W-1:0] tgt,
                                             input logic [NODE_W-1:0] src, input logic [NODE_W-1:0] dst);
    return {t, 2'b00, tgt, 8'h00, src, dst};
  endfunction

  function automatic logic [2:0] hdr_type(input logic [HDR_W-1:0] h);
    return h[22:20];
  endfunction

  function automatic logic [TGT_W-1:0] hdr_tgt(input logic [HDR_W-1:0] h);
    return h[17:16];
  endfunction

  function automatic logic [NODE_W-1:0] hdr_src(input logic [HDR_W-1:0] h);
    return h[7:4];
  endfunction

  function automatic logic [NODE_W-1:0] hdr_dst(input logic [HDR_W-1:0] h);
    return h[3:0];
  endfunction

  function automatic logic [ADDR_W-1:0] burst_addr(input logic [ADDR_W-1:0] base, input logic [CNT_W-1:0] idx);
    return base + (ADDR_W'(idx) << BURST_SH);
  endfunction
endpackage

// File: rtl/xfer_send.sv
module xfer_send
  import xfer_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] my_node,
  input  logic              start,
  input  logic [NODE_W-1:0] start_dst,
  input  logic [TGT_W-1:0]  start_tgt,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              perm_valid,
  input  logic [HDR_W-1:0]  perm_hdr,
  output logic              out_valid,
  output logic [HDR_W-1:0]  out_hdr,
  output logic [ARG_W-1:0]  out_arg,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int TO_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} s_state_e;
  s_state_e state;

  logic [NODE_W-1:0] dst_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [CNT_W-1:0]  cnt_q, idx_q;
  logic [TO_W-1:0]   wcnt_q;
  logic              open_q;

  // named event: a permission matching the open request
  logic perm_hit;
  assign perm_hit = (state == S_WAIT) && perm_valid && (hdr_type(perm_hdr) == PK_PERM)
                    && (hdr_src(perm_hdr) == dst_q) && (hdr_dst(perm_hdr) == my_node);
  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; out_valid <= 1'b0; out_hdr <= '0; out_arg <= '0;
      done <= 1'b0; err <= 1'b0; dst_q <= '0; tgt_q <= '0; cnt_q <= '0;
      idx_q <= '0; wcnt_q <= '0; open_q <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          dst_q <= start_dst; tgt_q <= start_tgt; cnt_q <= start_count;
          out_valid <= 1'b1;
          out_hdr   <= mk_hdr(PK_REQ, start_tgt, my_node, start_dst);
          out_arg   <= {start_count, start_addr};
          wcnt_q    <= '0;
          state     <= S_WAIT;
        end
        S_WAIT: begin
          if (perm_hit) begin
            if (cnt_q == '0) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              idx_q  <= '0;
              open_q <= 1'b1;
              state  <= S_SEND;
            end
          end else if (wcnt_q == TO_W'(TIMEOUT - 1)) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        S_SEND: begin
          out_valid <= 1'b1;
          out_hdr   <= mk_hdr(PK_DATA, tgt_q, my_node, dst_q);
          out_arg   <= {{ADDR_W{1'b0}}, idx_q};
          idx_q     <= idx_q + 1'b1;
          if (idx_q == cnt_q - 1'b1) begin
            done   <= 1'b1;
            open_q <= 1'b0;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_no_data_before_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && hdr_type(out_hdr) == PK_DATA) |-> $past(open_q));
  assert_request_follows_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start) |=> (out_valid && hdr_type(out_hdr) == PK_REQ));
  assert_err_excludes_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !busy));
  assert_done_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/xfer_recv.sv
module xfer_recv
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] my_node,
  input  logic              in_valid,
  input  logic [HDR_W-1:0]  in_hdr,
  input  logic [ARG_W-1:0]  in_arg,
  output logic              grant_valid,
  output logic [HDR_W-1:0]  grant_hdr,
  output logic              wr_valid,
  output logic [TGT_W-1:0]  wr_tgt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              busy,
  output logic              done
);
  typedef enum logic {R_IDLE, R_ACTIVE} r_state_e;
  r_state_e state;

  logic [NODE_W-1:0] src_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, n_q;
  logic              pend_v;
  logic [HDR_W-1:0]  pend_hdr;
  logic [ARG_W-1:0]  pend_arg;

  // named events
  logic in_req, data_hit, take;
  logic [HDR_W-1:0] sel_hdr;
  logic [ARG_W-1:0] sel_arg;
  assign in_req   = in_valid && (hdr_type(in_hdr) == PK_REQ) && (hdr_dst(in_hdr) == my_node);
  assign data_hit = in_valid && (state == R_ACTIVE) && (hdr_type(in_hdr) == PK_DATA)
                    && (hdr_src(in_hdr) == src_q) && (hdr_dst(in_hdr) == my_node);
  assign take     = (state == R_IDLE) && (pend_v || in_req);
  assign sel_hdr  = pend_v ? pend_hdr : in_hdr;
  assign sel_arg  = pend_v ? pend_arg : in_arg;
  assign busy     = (state == R_ACTIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= R_IDLE; grant_valid <= 1'b0; grant_hdr <= '0; wr_valid <= 1'b0;
      wr_tgt <= '0; wr_addr <= '0; done <= 1'b0; src_q <= '0; tgt_q <= '0;
      base_q <= '0; cnt_q <= '0; n_q <= '0; pend_v <= 1'b0; pend_hdr <= '0; pend_arg <= '0;
    end else begin
      grant_valid <= 1'b0;
      wr_valid    <= 1'b0;
      done        <= 1'b0;
      // one deferred-request slot
      if (in_req && !(state == R_IDLE && !pend_v)) begin
        pend_v <= 1'b1; pend_hdr <= in_hdr; pend_arg <= in_arg;
      end else if (state == R_IDLE && pend_v) begin
        pend_v <= 1'b0;
      end
      if (take) begin
        src_q  <= hdr_src(sel_hdr);
        tgt_q  <= hdr_tgt(sel_hdr);
        base_q <= sel_arg[ADDR_W-1:0];
        cnt_q  <= sel_arg[ARG_W-1:ADDR_W];
        n_q    <= '0;
        grant_valid <= 1'b1;
        grant_hdr   <= mk_hdr(PK_PERM, hdr_tgt(sel_hdr), my_node, hdr_src(sel_hdr));
        if (sel_arg[ARG_W-1:ADDR_W] == '0) done  <= 1'b1;
        else                               state <= R_ACTIVE;
      end
      if (data_hit) begin
        wr_valid <= 1'b1;
        wr_tgt   <= tgt_q;
        wr_addr  <= burst_addr(base_q, n_q);
        n_q      <= n_q + 1'b1;
        if (n_q == cnt_q - 1'b1) begin
          done  <= 1'b1;
          state <= R_IDLE;
        end
      end
    end
  end

  assert_count_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_hit |-> (n_q < cnt_q));
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_no_grant_midway_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == R_ACTIVE) |=> !grant_valid);
  assert_bad_type_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hdr_type(in_hdr) > 3'd4) |=> !wr_valid);
  assert_grant_write_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant_valid && wr_valid));
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int TIMEOUT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  my_node,
  input  logic        tx_start,
  input  logic [3:0]  tx_dst,
  input  logic [1:0]  tx_tgt,
  input  logic [23:0] tx_addr,
  input  logic [7:0]  tx_count,
  input  logic        tx_grant_valid,
  input  logic [22:0] tx_grant_hdr,
  output logic        tx_pkt_valid,
  output logic [22:0] tx_pkt_hdr,
  output logic [31:0] tx_pkt_arg,
  output logic        tx_busy,
  output logic        tx_done,
  output logic        tx_err,
  input  logic        rx_pkt_valid,
  input  logic [22:0] rx_pkt_hdr,
  input  logic [31:0] rx_pkt_arg,
  output logic        rx_grant_valid,
  output logic [22:0] rx_grant_hdr,
  output logic        wr_valid,
  output logic [1:0]  wr_tgt,
  output logic [23:0] wr_addr,
  output logic        rx_busy,
  output logic        rx_done
);
  xfer_send #(.TIMEOUT(TIMEOUT)) u_send (
    .clk(clk), .rst_n(rst_n), .my_node(my_node),
    .start(tx_start), .start_dst(tx_dst), .start_tgt(tx_tgt),
    .start_addr(tx_addr), .start_count(tx_count),
    .perm_valid(tx_grant_valid), .perm_hdr(tx_grant_hdr),
    .out_valid(tx_pkt_valid), .out_hdr(tx_pkt_hdr), .out_arg(tx_pkt_arg),
    .busy(tx_busy), .done(tx_done), .err(tx_err)
  );

  xfer_recv u_recv (
    .clk(clk), .rst_n(rst_n), .my_node(my_node),
    .in_valid(rx_pkt_valid), .in_hdr(rx_pkt_hdr), .in_arg(rx_pkt_arg),
    .grant_valid(rx_grant_valid), .grant_hdr(rx_grant_hdr),
    .wr_valid(wr_valid), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .busy(rx_busy), .done(rx_done)
  );
endmodule

// File: tb/sim_xfer_engine.sv
`timescale 1ns/1ps
module sim_xfer_engine;
  localparam int TO = 64;
  localparam logic [3:0] MY = 4'd5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic tx_start; logic [3:0] tx_dst; logic [1:0] tx_tgt; logic [23:0] tx_addr; logic [7:0] tx_count;
  logic tx_grant_valid; logic [22:0] tx_grant_hdr;
  logic tx_pkt_valid; logic [22:0] tx_pkt_hdr; logic [31:0] tx_pkt_arg;
  logic tx_busy, tx_done, tx_err;
  logic rx_pkt_valid; logic [22:0] rx_pkt_hdr; logic [31:0] rx_pkt_arg;
  logic rx_grant_valid; logic [22:0] rx_grant_hdr;
  logic wr_valid; logic [1:0] wr_tgt; logic [23:0] wr_addr; logic rx_busy, rx_done;

  xfer_engine #(.TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .my_node(MY),
    .tx_start(tx_start), .tx_dst(tx_dst), .tx_tgt(tx_tgt), .tx_addr(tx_addr), .tx_count(tx_count),
    .tx_grant_valid(tx_grant_valid), .tx_grant_hdr(tx_grant_hdr),
    .tx_pkt_valid(tx_pkt_valid), .tx_pkt_hdr(tx_pkt_hdr), .tx_pkt_arg(tx_pkt_arg),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_err(tx_err),
    .rx_pkt_valid(rx_pkt_valid), .rx_pkt_hdr(rx_pkt_hdr), .rx_pkt_arg(rx_pkt_arg),
    .rx_grant_valid(rx_grant_valid), .rx_grant_hdr(rx_grant_hdr),
    .wr_valid(wr_valid), .wr_tgt(wr_tgt), .wr_addr(wr_addr),
    .rx_busy(rx_busy), .rx_done(rx_done)
  );

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  function automatic logic [22:0] ehdr(int t, int tgt, int src, int dst);
    return 23'((t << 20) | (tgt << 16) | (src << 4) | dst);
  endfunction

  function automatic logic [23:0] eaddr(logic [23:0] base, int n);
    return 24'(base + n * 32);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  // ---------------- initiator side ----------------
  task automatic tx_open(logic [3:0] dst, logic [1:0] tgt, logic [23:0] addr, logic [7:0] cnt);
    tx_start = 1; tx_dst = dst; tx_tgt = tgt; tx_addr = addr; tx_count = cnt;
    @(negedge clk);
    tx_start = 0;
    chk("R2 request valid", 64'(tx_pkt_valid), 1);
    chk("R2 request header", 64'(tx_pkt_hdr), 64'(ehdr(0, tgt, MY, dst)));
    chk("R2 request arg", 64'(tx_pkt_arg), 64'({cnt, addr}));
  endtask

  task automatic tx_case(logic [3:0] dst, logic [1:0] tgt, logic [23:0] addr, logic [7:0] cnt);
    tx_open(dst, tgt, addr, cnt);
    // permission from a wrong source must be ignored
    tx_grant_valid = 1; tx_grant_hdr = ehdr(1, tgt, dst ^ 4'd1, MY);
    @(negedge clk);
    tx_grant_valid = 0;
    chk("R3 no data on foreign grant", 64'(tx_pkt_valid), 0);
    @(negedge clk);
    chk("R3 still waiting", 64'({tx_busy, tx_pkt_valid}), 64'(2'b10));
    tx_grant_valid = 1; tx_grant_hdr = ehdr(1, tgt, dst, MY);
    @(negedge clk);
    tx_grant_valid = 0;
    if (cnt == 0) begin
      chk("R10 tx done without data", 64'({tx_done, tx_pkt_valid, tx_busy}), 64'(3'b100));
    end else begin
      chk("R4 no data in grant cycle", 64'({tx_pkt_valid, tx_done}), 0);
      for (int i = 0; i < cnt; i++) begin
        @(negedge clk);
        chk("R4 data valid", 64'(tx_pkt_valid), 1);
        chk("R4 data header", 64'(tx_pkt_hdr), 64'(ehdr(3, tgt, MY, dst)));
        chk("R4 data index", 64'(tx_pkt_arg), 64'(i));
        chk("R4 done on last", 64'(tx_done), 64'(i == cnt - 1));
      end
      @(negedge clk);
      chk("R4 idle after stream", 64'({tx_busy, tx_pkt_valid}), 0);
    end
  endtask

  // ---------------- receiver side ----------------
  task automatic rx_send(logic [22:0] h, logic [31:0] a);
    rx_pkt_valid = 1; rx_pkt_hdr = h; rx_pkt_arg = a;
    @(negedge clk);
    rx_pkt_valid = 0;
  endtask

  task automatic rx_noise(logic [3:0] src);
    int kind = $urandom_range(0, 2);
    if (kind == 0) rx_send(ehdr($urandom_range(5, 7), 0, src, MY), $urandom);
    else if (kind == 1) rx_send(ehdr(0, 1, src, MY ^ 4'd3), {8'd2, 24'h100});
    else rx_send(ehdr(3, 0, src ^ 4'd8, MY), 0);
    chk("R1 R6 noise ignored", 64'({rx_grant_valid, wr_valid}), 0);
  endtask

  task automatic rx_data_run(logic [3:0] src, logic [1:0] tgt, logic [23:0] base, int cnt, bit noisy);
    for (int n = 0; n < cnt; n++) begin
      if (noisy && $urandom_range(0, 1) == 1) rx_noise(src);
      rx_send(ehdr(3, tgt, src, MY), 32'(n));
      chk("R7 write valid", 64'(wr_valid), 1);
      chk("R7 write address", 64'(wr_addr), 64'(eaddr(base, n)));
      chk("R7 write target", 64'(wr_tgt), 64'(tgt));
      chk("R8 done on last", 64'(rx_done), 64'(n == cnt - 1));
    end
  endtask

  task automatic rx_req(logic [3:0] src, logic [1:0] tgt, logic [23:0] base, logic [7:0] cnt);
    rx_send(ehdr(0, tgt, src, MY), {cnt, base});
    chk("R6 grant valid", 64'(rx_grant_valid), 1);
    chk("R6 grant header", 64'(rx_grant_hdr), 64'(ehdr(1, tgt, MY, src)));
    if (cnt == 0) chk("R10 rx done with grant", 64'({rx_done, rx_busy}), 64'(2'b10));
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        nfail++;
        $display("FAIL watchdog: got %0d expected below 100000", cyc);
        summary();
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; tx_start = 0; tx_dst = 0; tx_tgt = 0; tx_addr = 0; tx_count = 0;
    tx_grant_valid = 0; tx_grant_hdr = 0; rx_pkt_valid = 0; rx_pkt_hdr = 0; rx_pkt_arg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2 reset idle", 64'({tx_busy, tx_pkt_valid, tx_done, tx_err}), 0);
    chk("R8 reset idle", 64'({rx_busy, rx_grant_valid, wr_valid, rx_done}), 0);

    // directed initiator cases
    tx_case(4'd3, 2'd0, 24'h001000, 8'd5);
    tx_case(4'd9, 2'd1, 24'h000040, 8'd1);
    tx_case(4'd2, 2'd2, 24'h00ABC0, 8'd0);
    // random initiator cases
    for (int k = 0; k < 6; k++)
      tx_case(4'($urandom_range(0, 15)), 2'($urandom_range(0, 2)), 24'($urandom), 8'($urandom_range(1, 9)));

    // timeout
    tx_open(4'd7, 2'd0, 24'h0, 8'd3);
    for (int k = 1; k <= TO; k++) begin
      @(negedge clk);
      chk("R5 timeout flag", 64'(tx_err), 64'(k == TO));
    end
    chk("R5 idle after timeout", 64'(tx_busy), 0);

    // receiver: random transfers with interleaved noise
    for (int k = 0; k < 8; k++) begin
      logic [3:0] s = 4'($urandom_range(0, 15));
      logic [1:0] t = 2'($urandom_range(0, 2));
      logic [23:0] b = 24'($urandom);
      int c = $urandom_range(1, 7);
      rx_noise(s);
      rx_req(s, t, b, 8'(c));
      rx_data_run(s, t, b, c, 1'b1);
      rx_send(ehdr(3, t, s, MY), 0);
      chk("R8 no write after count", 64'(wr_valid), 0);
    end

    // address wrap at top of range
    rx_req(4'd1, 2'd0, 24'hFFFFE0, 8'd2);
    rx_data_run(4'd1, 2'd0, 24'hFFFFE0, 2, 1'b0);

    // count zero on receiver
    rx_req(4'd6, 2'd2, 24'h000200, 8'd0);
    rx_send(ehdr(3, 2, 6, MY), 0);
    chk("R10 no write after zero count", 64'(wr_valid), 0);

    // deferred request during a transfer
    rx_req(4'd1, 2'd0, 24'h004000, 8'd3);
    rx_send(ehdr(0, 1, 2, MY), {8'd2, 24'h008000});
    chk("R9 no grant while busy", 64'(rx_grant_valid), 0);
    rx_data_run(4'd1, 2'd0, 24'h004000, 3, 1'b0);
    chk("R9 done before deferred grant", 64'({rx_done, rx_grant_valid}), 64'(2'b10));
    @(negedge clk);
    chk("R9 deferred grant", 64'(rx_grant_valid), 1);
    chk("R9 deferred grant header", 64'(rx_grant_hdr), 64'(ehdr(1, 1, MY, 2)));
    rx_data_run(4'd2, 2'd1, 24'h008000, 2, 1'b0);

    finished = 1;
    summary();
  end
endmodule